// File: doc/BRIEF.md
# SDRAM Command Spacing Checker

This block sits beside a memory controller and watches its already decoded command stream (activate, read, write, precharge and write with auto-precharge), each command carrying a bank number. It flags every command that comes before the minimum gap the memory needs after an earlier command. A monitor or an on-chip self-test uses it to catch scheduler bugs as they happen, not after corrupted data shows up.

Each minimum gap is given in picoseconds. At elaboration the block turns it into whole clock cycles from a clock-period parameter, always rounding up. Gaps that start at the end of write data add a fixed count of cycles from the write command to the last data beat. One cycle after an offending command, the block raises a single-cycle violation flag together with a code that names the broken rule.

Top module: `sdram_spacing_check`

## Requirements
- R1: Every gap is the ceiling of its picosecond value divided by `TCK_PS`. The auto-precharge recovery gap is `WDATA_CYC + ceil(TWR_PS/TCK_PS) + ceil(TRP_PS/TCK_PS)`. The two terms are rounded separately and then added.
- R2: Command encoding on `cmd` is 0 idle, 1 activate, 2 read, 3 write, 4 precharge, 5 write with auto-precharge. The result for a command issued in cycle t appears on `viol`/`code` in cycle t+1 and lasts one cycle. `code` is 0 when `viol` is low, and otherwise one of 1 (bank-to-bank activate), 2 (write recovery), 3 (write-to-read), 4 (read-to-precharge), 5 (auto-precharge recovery).
- R3: An activate issued k cycles after the previous activate, to a different bank, violates with code 1 when k < ceil(TRRD_PS/TCK_PS).
- R4: A precharge to bank b issued k cycles after a plain write to bank b violates with code 2 when k < `WDATA_CYC` + ceil(TWR_PS/TCK_PS).
- R5: A read to any bank issued k cycles after a write or auto-precharge write to any bank violates with code 3 when k < `WDATA_CYC` + ceil(tWTR/TCK_PS). tWTR is 10000 ps when `SLOW_GRADE` is 1 and 7500 ps when it is 0.
- R6: A precharge to bank b issued k cycles after a read to bank b violates with code 4 when k < ceil(TRTP_PS/TCK_PS).
- R7: An activate to bank b issued k cycles after an auto-precharge write to bank b violates with code 5 when k is smaller than the gap of R1.
- R8: When one command breaks several rules, the lowest code is reported.
- R9: Idle commands never violate. Back-to-back activates to the same bank do not break the bank-to-bank rule. Each command restarts its gaps whether or not it violated.
- R10: Synchronous active-high `rst` clears all gap state and the outputs, so commands right after reset do not violate.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd | input | 3 | Decoded command (encoding in R2) |
| bank | input | $clog2(NUM_BANKS) | Bank addressed by the command |
| viol | output | 1 | One-cycle spacing violation flag |
| code | output | 3 | Rule broken, 0 when none |

## Verification
The bench builds the block with a 2000 ps clock period, the slow grade and two cycles of write data. Write recovery and precharge time each come to 7.5 clocks and round to 8, so the auto-precharge gap is 18 cycles. Rounding the sum in one step would give 17. The slow grade gives a write-to-read gap of 7 cycles, where the fast grade would give 6. Directed cases issue each rule at one cycle below and exactly at its gap. A long random stream is compared against a timestamp model.

// File: rtl/sdram_spacing_check.sv
module sdram_spacing_check #(
  parameter int TCK_PS     = 3000,
  parameter int TRRD_PS    = 7500,
  parameter int TWR_PS     = 15000,
  parameter int TRP_PS     = 15000,
  parameter int TRTP_PS    = 7500,
  parameter bit SLOW_GRADE = 1'b0,
  parameter int WDATA_CYC  = 4,
  parameter int NUM_BANKS  = 8,
  localparam int BW = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [2:0]    cmd,
  input  logic [BW-1:0] bank,
  output logic          viol,
  output logic [2:0]    code
);

  function automatic int cdiv(input int ps);
    return (ps + TCK_PS - 1) / TCK_PS;
  endfunction

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  localparam int TWTR_PS = SLOW_GRADE ? 10000 : 7500;
  localparam int S_RRD = cdiv(TRRD_PS);
  localparam int S_RTP = cdiv(TRTP_PS);
  localparam int S_WTR = WDATA_CYC + cdiv(TWTR_PS);
  localparam int S_WR  = WDATA_CYC + cdiv(TWR_PS);
  localparam int S_DAL = WDATA_CYC + cdiv(TWR_PS) + cdiv(TRP_PS);
  localparam int S_MAX = imax(imax(imax(S_RRD, S_RTP), imax(S_WTR, S_WR)), imax(S_DAL, 1));
  localparam int CW = $clog2(S_MAX + 1);

  localparam logic [CW-1:0] L_RRD = CW'(imax(S_RRD - 1, 0));
  localparam logic [CW-1:0] L_RTP = CW'(imax(S_RTP - 1, 0));
  localparam logic [CW-1:0] L_WTR = CW'(imax(S_WTR - 1, 0));
  localparam logic [CW-1:0] L_WR  = CW'(imax(S_WR  - 1, 0));
  localparam logic [CW-1:0] L_DAL = CW'(imax(S_DAL - 1, 0));

  function automatic logic [CW-1:0] dec(input logic [CW-1:0] c);
    return (c == '0) ? '0 : c - 1'b1;
  endfunction

  logic [CW-1:0] rrd_cnt, wtr_cnt;
  logic [BW-1:0] rrd_bank;
  logic [CW-1:0] wr_cnt  [NUM_BANKS];
  logic [CW-1:0] rtp_cnt [NUM_BANKS];
  logic [CW-1:0] dal_cnt [NUM_BANKS];

  wire is_nop = (cmd == 3'd0);
  wire is_act = (cmd == 3'd1);
  wire is_rd  = (cmd == 3'd2);
  wire is_wr  = (cmd == 3'd3);
  wire is_pre = (cmd == 3'd4);
  wire is_wra = (cmd == 3'd5);

  wire hit_rrd = is_act && (rrd_cnt != '0) && (bank != rrd_bank);
  wire hit_wr  = is_pre && (wr_cnt[bank] != '0);
  wire hit_wtr = is_rd  && (wtr_cnt != '0);
  wire hit_rtp = is_pre && (rtp_cnt[bank] != '0);
  wire hit_dal = is_act && (dal_cnt[bank] != '0);

  logic [2:0] nxt_code;
  always_comb begin
    if      (hit_rrd) nxt_code = 3'd1;
    else if (hit_wr)  nxt_code = 3'd2;
    else if (hit_wtr) nxt_code = 3'd3;
    else if (hit_rtp) nxt_code = 3'd4;
    else if (hit_dal) nxt_code = 3'd5;
    else              nxt_code = 3'd0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      viol     <= 1'b0;
      code     <= 3'd0;
      rrd_cnt  <= '0;
      wtr_cnt  <= '0;
      rrd_bank <= '0;
      for (int b = 0; b < NUM_BANKS; b++) begin
        wr_cnt[b]  <= '0;
        rtp_cnt[b] <= '0;
        dal_cnt[b] <= '0;
      end
    end else begin
      viol    <= (nxt_code != 3'd0);
      code    <= nxt_code;
      rrd_cnt <= is_act ? L_RRD : dec(rrd_cnt);
      wtr_cnt <= (is_wr || is_wra) ? L_WTR : dec(wtr_cnt);
      if (is_act) rrd_bank <= bank;
      for (int b = 0; b < NUM_BANKS; b++) begin
        wr_cnt[b]  <= (is_wr  && bank == BW'(b)) ? L_WR  : dec(wr_cnt[b]);
        rtp_cnt[b] <= (is_rd  && bank == BW'(b)) ? L_RTP : dec(rtp_cnt[b]);
        dal_cnt[b] <= (is_wra && bank == BW'(b)) ? L_DAL : dec(dal_cnt[b]);
      end
    end
  end

  assert_reset_clears_R10: assert property (@(posedge clk) rst |=> (!viol && code == 3'd0 && rrd_cnt == '0 && wtr_cnt == '0));
  assert_code_idle_R2: assert property (@(posedge clk) disable iff (rst) !viol |-> code == 3'd0);
  assert_code_range_R2: assert property (@(posedge clk) disable iff (rst) viol |-> (code >= 3'd1 && code <= 3'd5));
  assert_nop_quiet_R9: assert property (@(posedge clk) disable iff (rst) is_nop |=> !viol);
  assert_act_codes_R3: assert property (@(posedge clk) disable iff (rst) is_act |=> (!viol || code == 3'd1 || code == 3'd5));
  assert_pre_codes_R4: assert property (@(posedge clk) disable iff (rst) is_pre |=> (!viol || code == 3'd2 || code == 3'd4));
  assert_rd_codes_R5: assert property (@(posedge clk) disable iff (rst) is_rd |=> (!viol || code == 3'd3));
  assert_write_quiet_R9: assert property (@(posedge clk) disable iff (rst) (is_wr || is_wra) |=> !viol);
  assert_rrd_bound_R3: assert property (@(posedge clk) disable iff (rst) rrd_cnt <= L_RRD);
  assert_rrd_count_R3: assert property (@(posedge clk) disable iff (rst) (!is_act && rrd_cnt != '0) |=> rrd_cnt == $past(rrd_cnt) - 1'b1);
  assert_wtr_bound_R5: assert property (@(posedge clk) disable iff (rst) wtr_cnt <= L_WTR);

endmodule

// File: tb/sdram_spacing_check_test.sv
module sdram_spacing_check_test;
  localparam int TCK = 2000;
  localparam int NB = 8;

  function automatic int cd(input int ps);
    return (ps + TCK - 1) / TCK;
  endfunction

  localparam int E_RRD = cd(7500);
  localparam int E_RTP = cd(7500);
  localparam int E_WTR = 2 + cd(10000);
  localparam int E_WR  = 2 + cd(15000);
  localparam int E_DAL = 2 + cd(15000) + cd(15000);

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [2:0] cmd = 3'd0;
  logic [2:0] bank = 3'd0;
  logic viol;
  logic [2:0] code;

  always #4 clk = ~clk;

  sdram_spacing_check #(.TCK_PS(TCK), .SLOW_GRADE(1'b1), .WDATA_CYC(2), .NUM_BANKS(NB)) uut (
    .clk(clk), .rst(rst), .cmd(cmd), .bank(bank), .viol(viol), .code(code));

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  int t_act, act_bank, t_wany;
  int t_wr[NB];
  int t_rd[NB];
  int t_wra[NB];
  bit have_exp = 0;
  logic exp_v;
  logic [2:0] exp_c;
  string exp_tag;

  task automatic check(input logic v, input logic [2:0] c, input string tag);
    checks++;
    if (viol !== v || code !== c) begin
      errors++;
      $display("FAIL %s: viol=%0d code=%0d expected viol=%0d code=%0d", tag, viol, code, v, c);
    end
  endtask

  task automatic model_init();
    t_act = -1000; act_bank = 0; t_wany = -1000;
    for (int i = 0; i < NB; i++) begin
      t_wr[i] = -1000; t_rd[i] = -1000; t_wra[i] = -1000;
    end
  endtask

  task automatic step(input logic [2:0] c, input logic [2:0] b, input string tag);
    bit f1, f2, f3, f4, f5;
    @(negedge clk);
    if (have_exp) check(exp_v, exp_c, exp_tag);
    cmd = c; bank = b;
    f1 = (c == 3'd1) && (cyc - t_act < E_RRD) && (int'(b) != act_bank);
    f2 = (c == 3'd4) && (cyc - t_wr[b] < E_WR);
    f3 = (c == 3'd2) && (cyc - t_wany < E_WTR);
    f4 = (c == 3'd4) && (cyc - t_rd[b] < E_RTP);
    f5 = (c == 3'd1) && (cyc - t_wra[b] < E_DAL);
    exp_c = f1 ? 3'd1 : f2 ? 3'd2 : f3 ? 3'd3 : f4 ? 3'd4 : f5 ? 3'd5 : 3'd0;
    exp_v = (exp_c != 3'd0);
    exp_tag = tag;
    case (c)
      3'd1: begin t_act = cyc; act_bank = int'(b); end
      3'd2: t_rd[b] = cyc;
      3'd3: begin t_wr[b] = cyc; t_wany = cyc; end
      3'd5: begin t_wra[b] = cyc; t_wany = cyc; end
      default: ;
    endcase
    have_exp = 1;
    cyc++;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step(3'd0, 3'd0, "R9 idle");
  endtask

  task automatic do_reset();
    @(negedge clk);
    if (have_exp) check(exp_v, exp_c, exp_tag);
    have_exp = 0;
    rst = 1'b1; cmd = 3'd0;
    @(negedge clk);
    @(negedge clk);
    check(1'b0, 3'd0, "R10 outputs in reset");
    rst = 1'b0;
    model_init();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: run did not finish, actual=hung expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    model_init();
    do_reset();
    // R3: bank-to-bank activate, gap 4
    step(3'd1, 3'd0, "R3 first act"); idle(2); step(3'd1, 3'd1, "R3 act k=3");
    idle(20);
    step(3'd1, 3'd0, "R3 first act"); idle(3); step(3'd1, 3'd1, "R3 act k=4");
    idle(20);
    // R9: same-bank activates back to back
    step(3'd1, 3'd2, "R9 same bank"); step(3'd1, 3'd2, "R9 same bank k=1");
    idle(20);
    // R4: write recovery, gap 10
    step(3'd3, 3'd2, "R4 write"); idle(8); step(3'd4, 3'd2, "R4 pre k=9");
    idle(20);
    step(3'd3, 3'd2, "R4 write"); idle(9); step(3'd4, 3'd2, "R4 pre k=10");
    idle(20);
    // R5: write-to-read slow grade, gap 7
    step(3'd3, 3'd6, "R5 write"); idle(5); step(3'd2, 3'd1, "R5 read k=6");
    idle(20);
    step(3'd5, 3'd6, "R5 wra"); idle(6); step(3'd2, 3'd1, "R5 read k=7");
    idle(20);
    // R6: read-to-precharge, gap 4
    step(3'd2, 3'd3, "R6 read"); idle(2); step(3'd4, 3'd3, "R6 pre k=3");
    idle(20);
    step(3'd2, 3'd3, "R6 read"); idle(3); step(3'd4, 3'd3, "R6 pre k=4");
    idle(20);
    // R7/R1: auto-precharge recovery, separate rounding gives 18
    step(3'd5, 3'd4, "R7 wra"); idle(16); step(3'd1, 3'd4, "R1 R7 act k=17");
    idle(30);
    step(3'd5, 3'd4, "R7 wra"); idle(17); step(3'd1, 3'd4, "R1 R7 act k=18");
    idle(30);
    // R8: priority
    step(3'd5, 3'd6, "R8 wra"); step(3'd1, 3'd0, "R8 act"); step(3'd1, 3'd6, "R8 act codes 1+5");
    idle(30);
    step(3'd2, 3'd7, "R8 read"); step(3'd3, 3'd7, "R8 write"); step(3'd4, 3'd7, "R8 pre codes 2+4");
    idle(30);
    // R10: reset clears pending gaps
    step(3'd3, 3'd5, "R10 write"); step(3'd1, 3'd0, "R10 act");
    do_reset();
    step(3'd4, 3'd5, "R10 pre after reset"); step(3'd2, 3'd5, "R10 read after reset");
    step(3'd1, 3'd1, "R10 act after reset");
    idle(20);
    // Random stream, all rules
    for (int i = 0; i < 4000; i++) begin
      int r;
      logic [2:0] c;
      r = $urandom % 12;
      c = (r < 5) ? 3'd0 : (r < 7) ? 3'd1 : (r < 8) ? 3'd2 : (r < 9) ? 3'd3 : (r < 11) ? 3'd4 : 3'd5;
      step(c, 3'($urandom % NB), "R2 random");
    end
    idle(2);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule